// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a single-port synchronous static memory that accepts one command per clock (read, write or deselect) and mixes reads and writes in any order without idle cycles. Every command input is registered on the rising edge. A read returns its word in the clock period that follows its command edge, fed straight from the array with no output register. A write takes its data one edge after its address, so read data and write data share the same data cycle slot and the bus never needs a turnaround gap.

The array is updated late: captured write data sits in a one-entry pending buffer until the next write's data arrives, and reads of that address take the pending bytes from the buffer. A low-active clock enable stalls the whole pipeline. Three chip selects form the device select. An asynchronous output enable gates the drivers. The three-state bus is presented as a separate input, output and drive-enable. The width is 36 bits in four 9-bit lanes. The depth is a parameter.

The command register is a three-state machine for the data cycle: IDLE (no drive), READ (array word on the bus) and WRITE (bus released, data awaited). On each enabled edge a deselected command takes any state to IDLE, a selected read takes it to READ and a selected write takes it to WRITE. A stalled edge keeps the state.

Top module: `zbt_sram`

## Requirements
- R1: A selected read (wr_n high) sampled at an enabled rising edge drives the addressed word on dq_o, with dq_oe high, from that edge until the next enabled edge, provided drv_en_n is low.
- R2: An edge with clk_en_n high has no effect: no command, write data or state is taken, and dq_o/dq_oe keep their values.
- R3: Any sequence of reads, writes and deselects, one per enabled edge, is served with no wait states, and every read returns the most recent data written to its address.
- R4: A write is a selected command with wr_n low. Bit i of lane_wr_n, when low, enables lane i, which holds data bits 9*i+8 down to 9*i. Disabled lanes keep their old contents.
- R5: The device is selected only when cs_a_n is 0, cs_b is 1 and cs_c_n is 0. Any other combination is a deselect that changes no stored data.
- R6: drv_en_n is asynchronous. While it is high, dq_oe is low within the same cycle, and the read word reappears when it falls again.
- R7: Write data for a write sampled at enabled edge N is taken from dq_i at the next enabled edge.
- R8: During the data cycle of a write, dq_oe is low whatever drv_en_n is.
- R9: A read issued right after a write to the same address returns the new bytes in the enabled lanes and the old bytes in the others.
- R10: After a deselect edge, dq_oe is low until the next enabled edge.
- R11: While rst_n is low and after it is released, dq_oe is low and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the block |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Low for write, high for read |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| addr | input | AW | Word address (AW = log2 of DEPTH) |
| drv_en_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 36 | Write data seen on the bus |
| dq_o | output | 36 | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable; low means high impedance |

## Verification
The hardest case to reach is a read that must draw some lanes from the pending buffer and others from the array. It occurs only when a partial-lane write is followed at once by a read of the same address, and when no later write has yet pushed that buffer into the array. Stalls landing inside a write's data cycle make it harder still. The stimulus gets there with directed write-then-read pairs using alternating lane masks. It also runs a long random mix over only eight addresses, with stalls and toggled output enables, so pending hits happen often. A behavioural model that writes at once is compared on every cycle.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

endpackage

// File: rtl/zbt_cmd_reg.sv
module zbt_cmd_reg
    import zbt_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en_n,
    input  logic             cs_a_n,
    input  logic             cs_b,
    input  logic             cs_c_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic [AW-1:0]    addr,
    output phase_e           phase,
    output logic [AW-1:0]    cur_addr,
    output logic [LANES-1:0] cur_mask
);

    logic   selected;
    phase_e phase_nxt;

    assign selected = !cs_a_n && cs_b && !cs_c_n;

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_IDLE, PH_READ, PH_WRITE: begin
                if (!selected)  phase_nxt = PH_IDLE;
                else if (wr_n)  phase_nxt = PH_READ;
                else            phase_nxt = PH_WRITE;
            end
            default: phase_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cur_addr <= '0;
            cur_mask <= '0;
        end else if (!clk_en_n) begin
            phase <= phase_nxt;
            if (selected) begin
                cur_addr <= addr;
                cur_mask <= ~lane_wr_n;
            end
        end
    end

    a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(phase) && $stable(cur_addr) && $stable(cur_mask)));

    a_r10_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !(!cs_a_n && cs_b && !cs_c_n)) |=> (phase == PH_IDLE));

    a_r8_write_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !cs_a_n && cs_b && !cs_c_n && !wr_n) |=> (phase == PH_WRITE));

endmodule

// File: rtl/zbt_wr_buffer.sv
module zbt_wr_buffer #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [AW-1:0]    ld_addr,
    input  logic [LANES-1:0] ld_mask,
    input  logic [DW-1:0]    ld_data,
    output logic             pend_vld,
    output logic [AW-1:0]    pend_addr,
    output logic [LANES-1:0] pend_mask,
    output logic [DW-1:0]    pend_data,
    output logic             commit
);

    // The previous entry goes to the array on the same edge a new one arrives.
    assign commit = load && pend_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            pend_mask <= '0;
            pend_data <= '0;
        end else if (load) begin
            pend_vld  <= 1'b1;
            pend_addr <= ld_addr;
            pend_mask <= ld_mask;
            pend_data <= ld_data;
        end
    end

    a_r7_capture_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> pend_vld);

    a_r11_pending_only_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_vld && !load) |=> !pend_vld);

endmodule

// File: rtl/zbt_store.sv
module zbt_store #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DEPTH = 1 << AW,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [LANES-1:0] wmask,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[g])
                cells[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en_n,
    input  logic             cs_a_n,
    input  logic             cs_b,
    input  logic             cs_c_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic [AW-1:0]    addr,
    input  logic             drv_en_n,
    input  logic [DW-1:0]    dq_i,
    output logic [DW-1:0]    dq_o,
    output logic             dq_oe
);

    phase_e           phase;
    logic [AW-1:0]    cur_addr;
    logic [LANES-1:0] cur_mask;
    logic             load;
    logic             pend_vld;
    logic [AW-1:0]    pend_addr;
    logic [LANES-1:0] pend_mask;
    logic [DW-1:0]    pend_data;
    logic             commit;
    logic [DW-1:0]    arr_word;
    logic [DW-1:0]    fwd_word;
    logic             pend_hit;

    zbt_cmd_reg #(.AW(AW), .LANES(LANES)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en_n  (clk_en_n),
        .cs_a_n    (cs_a_n),
        .cs_b      (cs_b),
        .cs_c_n    (cs_c_n),
        .wr_n      (wr_n),
        .lane_wr_n (lane_wr_n),
        .addr      (addr),
        .phase     (phase),
        .cur_addr  (cur_addr),
        .cur_mask  (cur_mask)
    );

    // Write data is taken on the enabled edge that closes a write data cycle.
    assign load = !clk_en_n && (phase == PH_WRITE);

    zbt_wr_buffer #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ld_addr   (cur_addr),
        .ld_mask   (cur_mask),
        .ld_data   (dq_i),
        .pend_vld  (pend_vld),
        .pend_addr (pend_addr),
        .pend_mask (pend_mask),
        .pend_data (pend_data),
        .commit    (commit)
    );

    zbt_store #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk   (clk),
        .we    (commit),
        .waddr (pend_addr),
        .wmask (pend_mask),
        .wdata (pend_data),
        .raddr (cur_addr),
        .rdata (arr_word)
    );

    assign pend_hit = pend_vld && (pend_addr == cur_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign fwd_word[g*LANE_W +: LANE_W] = (pend_hit && pend_mask[g])
            ? pend_data[g*LANE_W +: LANE_W]
            : arr_word[g*LANE_W +: LANE_W];
    end

    always_comb begin
        dq_o  = '0;
        dq_oe = 1'b0;
        unique case (phase)
            PH_READ: begin
                dq_oe = !drv_en_n;
                dq_o  = drv_en_n ? '0 : fwd_word;
            end
            PH_WRITE: begin
                dq_oe = 1'b0;
            end
            default: begin
                dq_oe = 1'b0;
            end
        endcase
    end

    a_r9_commit_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (pend_vld && phase == PH_WRITE));

endmodule

// File: tb/sim_zbt_sram.sv
module sim_zbt_sram;

    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int DW    = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          cs_a_n = 1'b1;
    logic          cs_b = 1'b0;
    logic          cs_c_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [3:0]    lane_wr_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic          drv_en_n = 1'b0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // Behavioural model: writes land in ref_mem immediately at data capture.
    logic [DW-1:0] ref_mem [DEPTH];
    int            ref_ph = 0;   // 0 idle, 1 read, 2 write
    int            ref_addr = 0;
    logic [3:0]    ref_mask = '0;

    always #5 clk = ~clk;

    zbt_sram u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en_n  (clk_en_n),
        .cs_a_n    (cs_a_n),
        .cs_b      (cs_b),
        .cs_c_n    (cs_c_n),
        .wr_n      (wr_n),
        .lane_wr_n (lane_wr_n),
        .addr      (addr),
        .drv_en_n  (drv_en_n),
        .dq_i      (dq_i),
        .dq_o      (dq_o),
        .dq_oe     (dq_oe)
    );

    task automatic compare(input string tag);
        logic          exp_oe;
        logic [DW-1:0] exp_d;
        exp_oe = (ref_ph == 1) && !drv_en_n;
        exp_d  = ref_mem[ref_addr];
        compared++;
        if (dq_oe !== exp_oe || (exp_oe && dq_o !== exp_d)) begin
            mismatched++;
            $display("FAIL %s t=%0t: oe=%b data=%h, expected oe=%b data=%h",
                     tag, $time, dq_oe, dq_o, exp_oe, exp_d);
        end
    endtask

    task automatic step(input logic cen, input logic [2:0] cs, input logic w,
                        input logic [3:0] bw, input int a, input logic oe,
                        input string tag);
        logic [63:0] r;
        @(negedge clk);
        r = {$urandom, $urandom};
        clk_en_n = cen;
        {cs_a_n, cs_b, cs_c_n} = cs;
        wr_n = w;
        lane_wr_n = bw;
        addr = AW'(a);
        drv_en_n = oe;
        dq_i = r[DW-1:0];
        @(posedge clk);
        if (!cen) begin
            if (ref_ph == 2)
                for (int l = 0; l < 4; l++)
                    if (ref_mask[l]) ref_mem[ref_addr][l*9 +: 9] = dq_i[l*9 +: 9];
            if (cs == 3'b010) begin
                ref_ph = w ? 1 : 2;
                ref_addr = a;
                ref_mask = ~bw;
            end else begin
                ref_ph = 0;
            end
        end
        #2;
        compare(tag);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R11: outputs released in and after reset
        repeat (3) @(posedge clk);
        #2 compare("R11 in reset");
        @(negedge clk) rst_n = 1'b1;
        step(1'b0, 3'b110, 1'b1, 4'hF, 0, 1'b0, "R11 after reset");

        // R4 R7: fill every word with full-lane writes, back to back
        for (int i = 0; i < DEPTH; i++)
            step(1'b0, 3'b010, 1'b0, 4'h0, i, 1'b0, "R7 fill");
        // R1: read all words back, first read directly after last write
        for (int i = 0; i < DEPTH; i++)
            step(1'b0, 3'b010, 1'b1, 4'hF, i, 1'b0, "R1 read");

        // R9: partial write then immediate read of the same address
        step(1'b0, 3'b010, 1'b0, 4'b0101, 5, 1'b0, "R8 write cycle");
        step(1'b0, 3'b010, 1'b1, 4'hF, 5, 1'b0, "R9 forward");
        step(1'b0, 3'b010, 1'b0, 4'b1010, 5, 1'b0, "R4 other lanes");
        step(1'b0, 3'b010, 1'b1, 4'hF, 5, 1'b0, "R9 forward 2");
        step(1'b0, 3'b010, 1'b1, 4'hF, 6, 1'b0, "R1 other addr");

        // R8: write data cycle is undriven even with output enable low
        step(1'b0, 3'b010, 1'b0, 4'h0, 7, 1'b0, "R8 no drive");
        // R2: stall during write data cycle, data taken at next enabled edge
        step(1'b1, 3'b010, 1'b1, 4'hF, 9, 1'b0, "R2 stall write");
        step(1'b1, 3'b110, 1'b0, 4'h0, 3, 1'b0, "R2 stall write 2");
        step(1'b0, 3'b010, 1'b1, 4'hF, 7, 1'b0, "R7 stalled data");
        // R2: stall during a read keeps the word
        step(1'b1, 3'b010, 1'b0, 4'h0, 7, 1'b0, "R2 stall read");
        step(1'b0, 3'b010, 1'b1, 4'hF, 7, 1'b0, "R2 after stall");

        // R5: each select pin on its own deselects; attempted writes change nothing
        step(1'b0, 3'b110, 1'b0, 4'h0, 7, 1'b0, "R5 cs_a_n high");
        step(1'b0, 3'b000, 1'b0, 4'h0, 7, 1'b0, "R5 cs_b low");
        step(1'b0, 3'b011, 1'b0, 4'h0, 7, 1'b0, "R5 cs_c_n high");
        step(1'b0, 3'b010, 1'b1, 4'hF, 7, 1'b0, "R5 data kept");
        // R10: deselect after read releases the bus
        step(1'b0, 3'b000, 1'b1, 4'hF, 7, 1'b0, "R10 deselect");

        // R6: output enable toggled inside a read cycle
        step(1'b0, 3'b010, 1'b1, 4'hF, 8, 1'b0, "R6 read");
        drv_en_n = 1'b1;
        #1 compare("R6 oe high");
        drv_en_n = 1'b0;
        #1 compare("R6 oe low again");

        // R3: random mix over few addresses, with stalls and oe changes
        for (int k = 0; k < 3000; k++) begin
            logic [2:0] cs;
            cs = ($urandom % 6 == 0) ? 3'($urandom) : 3'b010;
            step(($urandom % 5 == 0), cs, 1'($urandom), 4'($urandom),
                 int'($urandom % 8), ($urandom % 10 == 0), "R3 mix");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule